// File: doc/BRIEF.md
# Predicate Register Compare Unit

This block holds a file of 64 one-bit predicate flags and the logic that writes compare results into them. A compare operation arrives with two 64-bit operands, each carrying a "not a value" (NaT) marker. It also carries a condition code, a compare type, the index of a qualifying predicate and two target indices. The block evaluates the condition and reads the qualifying predicate. It then writes zero, one or both targets, as the compare type dictates. Some types always write both targets. Others write only when the condition, or the qualifying predicate, allows it, so that chains of AND or OR terms can build up in a predicate across several operations.

A 64-bit bulk port reads all predicates as one word and can load them all at the clock edge. This lets the whole file be saved and restored. Predicate 0 is hard-wired TRUE.

Compares enter on a valid/ready handshake. An operation is accepted in any cycle where `cmp_valid` and `cmp_ready` are both high. `cmp_ready` falls only while a bulk write is in progress, and a compare presented in that cycle must be held until `cmp_ready` returns. The bulk port is plain control, and its write always wins. All writes land at the rising clock edge. All reads are combinational from the stored state.

Top module: `pred_cmp_unit`

## Requirements
- R1: Predicate 0 always reads as 1 on `bulk_rd[0]`, and no compare or bulk write changes that.
- R2: Normal type (code 0) with a TRUE qualifying predicate writes the condition result to the first target and its complement to the second target. If both targets are the same index, the first-target value is the one stored.
- R3: Unconditional type (code 1) writes 0 to both targets when the qualifying predicate is FALSE. When the qualifying predicate is TRUE, it acts as the normal type.
- R4: For every type except unconditional, a FALSE qualifying predicate leaves all predicates unchanged.
- R5: AND type (code 2) writes 0 to both targets when the condition is false, and otherwise leaves them alone. ANDCM type (code 4) writes 0 to both targets when the condition is true, and otherwise leaves them alone.
- R6: OR type (code 3) writes 1 to both targets when the condition is true. ORCM type (code 5) writes 1 to both targets when the condition is false. Neither type writes otherwise.
- R7: Mixed type code 6 sets the first target to first AND cond and the second target to second OR NOT cond. Mixed type code 7 sets the first target to first OR cond and the second target to second AND NOT cond.
- R8: If either operand's NaT flag is set, the condition result is taken as false.
- R9: Condition codes are: 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than.
- R10: A bulk write loads predicates 1 to 63 from `bulk_wd[63:1]` at the next edge. `bulk_rd` always shows all 64 predicates, with bit i holding predicate i.
- R11: After reset, predicates 1 to 63 are 0. `cmp_ready` is low exactly while `bulk_we` is high, and a compare offered in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare operation offered |
| cmp_ready | output | 1 | Compare can be accepted this cycle |
| cmp_type | input | 3 | Compare type code (see R2 to R7) |
| cmp_cond | input | 2 | Condition code (see R9) |
| cmp_qp | input | 6 | Qualifying predicate index |
| cmp_t1 | input | 6 | First target predicate index |
| cmp_t2 | input | 6 | Second target predicate index |
| opa | input | 64 | First operand |
| opa_nat | input | 1 | First operand NaT flag |
| opb | input | 64 | Second operand |
| opb_nat | input | 1 | Second operand NaT flag |
| bulk_we | input | 1 | Load all predicates from `bulk_wd` |
| bulk_wd | input | 64 | Bulk write data |
| bulk_rd | output | 64 | All predicates, bit i is predicate i |

## Verification
The assertions take it that the driver follows the handshake: it never expects a compare to take effect in a cycle where `bulk_we` is high. The target-index checks also assume that the indices presented with an accepted compare are meaningful at that edge. The stimulus changes inputs only on the falling edge and offers at most one compare or one bulk write per cycle, except in one deliberate collision case. It sets up the predicate file with a bulk write before each scenario, so that every expected value follows from a known starting state.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    C_EQ  = 2'd0,
    C_NE  = 2'd1,
    C_LT  = 2'd2,
    C_LTU = 2'd3
  } cond_e;

  typedef enum logic [2:0] {
    T_NORM     = 3'd0,
    T_UNC      = 3'd1,
    T_AND      = 3'd2,
    T_OR       = 3'd3,
    T_ANDCM    = 3'd4,
    T_ORCM     = 3'd5,
    T_AND_ORCM = 3'd6,
    T_OR_ANDCM = 3'd7
  } ctype_e;

  typedef struct packed {
    logic we;
    logic d;
  } pwr_t;
endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
  import pcu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic              a_nat,
  input  logic [DATA_W-1:0] b,
  input  logic              b_nat,
  input  cond_e             cond,
  output logic              res
);
  logic raw;

  always_comb begin
    unique case (cond)
      C_EQ:    raw = (a == b);
      C_NE:    raw = (a != b);
      C_LT:    raw = ($signed(a) < $signed(b));
      default: raw = (a < b);
    endcase
    // a poisoned operand never yields a true condition
    res = raw & ~(a_nat | b_nat);
  end
endmodule

// File: rtl/pcu_write_ctrl.sv
module pcu_write_ctrl
  import pcu_pkg::*;
(
  input  logic   fire,
  input  logic   qp,
  input  logic   res,
  input  ctype_e ctype,
  output pwr_t   w1,
  output pwr_t   w2
);
  always_comb begin
    w1 = '0;
    w2 = '0;
    if (fire) begin
      if (!qp) begin
        if (ctype == T_UNC) begin
          w1 = '{we: 1'b1, d: 1'b0};
          w2 = '{we: 1'b1, d: 1'b0};
        end
      end else begin
        unique case (ctype)
          T_NORM, T_UNC: begin
            w1 = '{we: 1'b1, d: res};
            w2 = '{we: 1'b1, d: ~res};
          end
          T_AND: begin
            w1 = '{we: ~res, d: 1'b0};
            w2 = '{we: ~res, d: 1'b0};
          end
          T_ANDCM: begin
            w1 = '{we: res, d: 1'b0};
            w2 = '{we: res, d: 1'b0};
          end
          T_OR: begin
            w1 = '{we: res, d: 1'b1};
            w2 = '{we: res, d: 1'b1};
          end
          T_ORCM: begin
            w1 = '{we: ~res, d: 1'b1};
            w2 = '{we: ~res, d: 1'b1};
          end
          T_AND_ORCM: begin
            w1 = '{we: ~res, d: 1'b0};
            w2 = '{we: ~res, d: 1'b1};
          end
          default: begin
            w1 = '{we: res, d: 1'b1};
            w2 = '{we: res, d: 1'b0};
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file
  import pcu_pkg::*;
#(
  parameter int NPRED = 64,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bulk_we,
  input  logic [NPRED-1:0] bulk_wd,
  input  pwr_t             w1,
  input  logic [IDX_W-1:0] idx1,
  input  pwr_t             w2,
  input  logic [IDX_W-1:0] idx2,
  output logic [NPRED-1:0] vec
);
  logic [NPRED-1:0] q;

  assign q[0] = 1'b1;

  for (genvar i = 1; i < NPRED; i++) begin : g_bit
    logic hit1, hit2, nxt;
    assign hit1 = w1.we && (idx1 == IDX_W'(i));
    assign hit2 = w2.we && (idx2 == IDX_W'(i));
    // first target outranks second on a shared index
    assign nxt  = bulk_we ? bulk_wd[i] : hit1 ? w1.d : hit2 ? w2.d : q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end

  assign vec = q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bulk_we && !w1.we && !w2.we) |=> $stable(vec)); // R4
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pcu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NPRED  = 64,
  localparam int IDX_W = $clog2(NPRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [2:0]        cmp_type,
  input  logic [1:0]        cmp_cond,
  input  logic [IDX_W-1:0]  cmp_qp,
  input  logic [IDX_W-1:0]  cmp_t1,
  input  logic [IDX_W-1:0]  cmp_t2,
  input  logic [DATA_W-1:0] opa,
  input  logic              opa_nat,
  input  logic [DATA_W-1:0] opb,
  input  logic              opb_nat,
  input  logic              bulk_we,
  input  logic [NPRED-1:0]  bulk_wd,
  output logic [NPRED-1:0]  bulk_rd
);
  logic   fire, res, qp_val;
  pwr_t   w1, w2;
  ctype_e ctype;

  assign cmp_ready = ~bulk_we;
  assign fire      = cmp_valid & cmp_ready;
  assign ctype     = ctype_e'(cmp_type);
  assign qp_val    = bulk_rd[cmp_qp];

  pcu_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .a(opa), .a_nat(opa_nat), .b(opb), .b_nat(opb_nat),
    .cond(cond_e'(cmp_cond)), .res(res)
  );

  pcu_write_ctrl u_wctl (
    .fire(fire), .qp(qp_val), .res(res), .ctype(ctype), .w1(w1), .w2(w2)
  );

  pcu_pred_file #(.NPRED(NPRED)) u_file (
    .clk(clk), .rst_n(rst_n), .bulk_we(bulk_we), .bulk_wd(bulk_wd),
    .w1(w1), .idx1(cmp_t1), .w2(w2), .idx2(cmp_t2), .vec(bulk_rd)
  );

  AST_P0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmp_t1 == '0) |=> bulk_rd[0]); // R1

  AST_NORM_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && qp_val && ctype == T_NORM && cmp_t1 != cmp_t2 && cmp_t1 != '0 && cmp_t2 != '0)
    |=> (bulk_rd[$past(cmp_t1)] != bulk_rd[$past(cmp_t2)])); // R2

  AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !qp_val && ctype == T_UNC && cmp_t1 != '0) |=> !bulk_rd[$past(cmp_t1)]); // R3

  AST_QP_FALSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !qp_val && ctype != T_UNC) |=> $stable(bulk_rd)); // R4

  AST_NAT_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && qp_val && ctype == T_NORM && (opa_nat || opb_nat) && cmp_t1 != '0)
    |=> !bulk_rd[$past(cmp_t1)]); // R8

  AST_BULK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_we |=> (bulk_rd == ($past(bulk_wd) | NPRED'(1)))); // R10

  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_we |-> !cmp_ready); // R11
endmodule

// File: tb/test_pred_cmp_unit.sv
module test_pred_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [2:0]  cmp_type = '0;
  logic [1:0]  cmp_cond = '0;
  logic [5:0]  cmp_qp = '0, cmp_t1 = '0, cmp_t2 = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        opa_nat = 1'b0, opb_nat = 1'b0;
  logic        bulk_we = 1'b0;
  logic [63:0] bulk_wd = '0;
  logic [63:0] bulk_rd;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pred_cmp_unit i_pred_cmp_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_type(cmp_type), .cmp_cond(cmp_cond), .cmp_qp(cmp_qp),
    .cmp_t1(cmp_t1), .cmp_t2(cmp_t2), .opa(opa), .opa_nat(opa_nat),
    .opb(opb), .opb_nat(opb_nat), .bulk_we(bulk_we), .bulk_wd(bulk_wd),
    .bulk_rd(bulk_rd)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_all(input logic [63:0] v);
    @(negedge clk);
    bulk_we = 1'b1; bulk_wd = v;
    @(negedge clk);
    bulk_we = 1'b0;
  endtask

  task automatic cmp(input logic [2:0] typ, input logic [1:0] cnd, input logic [5:0] qp,
                     input logic [5:0] t1, input logic [5:0] t2,
                     input logic [63:0] a, input logic na, input logic [63:0] b, input logic nb);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_type = typ; cmp_cond = cnd; cmp_qp = qp;
    cmp_t1 = t1; cmp_t2 = t2; opa = a; opa_nat = na; opb = b; opb_nat = nb;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  function automatic logic [63:0] bm(input int i);
    return 64'd1 << i;
  endfunction

  task automatic t_reset;
    check("R11 reset state", bulk_rd, 64'd1);
    check("R11 ready idle", {63'd0, cmp_ready}, 64'd1);
  endtask

  task automatic t_bulk;
    set_all(64'hA5A5_0F0F_3C3C_1234);
    check("R10 bulk load", bulk_rd, 64'hA5A5_0F0F_3C3C_1235);
    set_all(64'hFFFF_FFFF_FFFF_FFFE);
    check("R1 bit0 after bulk", bulk_rd, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_normal;
    set_all(64'd0);
    cmp(3'd0, 2'd0, 6'd0, 6'd5, 6'd6, 64'd7, 1'b0, 64'd7, 1'b0);
    check("R2 normal eq true", bulk_rd, 64'd1 | bm(5));
    cmp(3'd0, 2'd0, 6'd0, 6'd5, 6'd6, 64'd7, 1'b0, 64'd8, 1'b0);
    check("R2 normal eq false", bulk_rd, 64'd1 | bm(6));
    set_all(64'd0);
    cmp(3'd0, 2'd0, 6'd0, 6'd7, 6'd7, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R2 shared target first wins", bulk_rd, 64'd1 | bm(7));
    cmp(3'd0, 2'd0, 6'd0, 6'd0, 6'd8, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R1 write to p0 ignored", bulk_rd, 64'd1 | bm(7) | bm(8));
  endtask

  task automatic t_conds;
    set_all(64'd0);
    cmp(3'd0, 2'd1, 6'd0, 6'd10, 6'd11, 64'd3, 1'b0, 64'd4, 1'b0);
    check("R9 ne", bulk_rd, 64'd1 | bm(10));
    cmp(3'd0, 2'd2, 6'd0, 6'd10, 6'd11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd1, 1'b0);
    check("R9 signed lt", bulk_rd, 64'd1 | bm(10));
    cmp(3'd0, 2'd3, 6'd0, 6'd10, 6'd11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd1, 1'b0);
    check("R9 unsigned lt", bulk_rd, 64'd1 | bm(11));
  endtask

  task automatic t_qp;
    set_all(bm(20) | bm(21));
    cmp(3'd0, 2'd0, 6'd9, 6'd20, 6'd21, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R4 qp false normal", bulk_rd, 64'd1 | bm(20) | bm(21));
    cmp(3'd3, 2'd0, 6'd9, 6'd22, 6'd23, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R4 qp false or", bulk_rd, 64'd1 | bm(20) | bm(21));
    cmp(3'd1, 2'd0, 6'd9, 6'd20, 6'd21, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R3 unc qp false clears", bulk_rd, 64'd1);
    set_all(bm(9));
    cmp(3'd1, 2'd0, 6'd9, 6'd20, 6'd21, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R3 unc qp true", bulk_rd, 64'd1 | bm(9) | bm(20));
  endtask

  task automatic t_nat;
    set_all(64'd0);
    cmp(3'd0, 2'd0, 6'd0, 6'd5, 6'd6, 64'd3, 1'b1, 64'd3, 1'b0);
    check("R8 nat a forces false", bulk_rd, 64'd1 | bm(6));
    set_all(bm(5) | bm(6));
    cmp(3'd3, 2'd0, 6'd0, 6'd5, 6'd6, 64'd3, 1'b0, 64'd3, 1'b1);
    check("R8 nat b or keeps", bulk_rd, 64'd1 | bm(5) | bm(6));
  endtask

  task automatic t_parallel;
    set_all(bm(30) | bm(31));
    cmp(3'd2, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R5 and true keeps", bulk_rd, 64'd1 | bm(30) | bm(31));
    cmp(3'd2, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R5 and false clears", bulk_rd, 64'd1);
    set_all(bm(30) | bm(31));
    cmp(3'd4, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R5 andcm true clears", bulk_rd, 64'd1);
    cmp(3'd3, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R6 or false keeps", bulk_rd, 64'd1);
    cmp(3'd3, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R6 or true sets", bulk_rd, 64'd1 | bm(30) | bm(31));
    set_all(64'd0);
    cmp(3'd5, 2'd0, 6'd0, 6'd30, 6'd31, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R6 orcm false sets", bulk_rd, 64'd1 | bm(30) | bm(31));
  endtask

  task automatic t_mixed;
    set_all(bm(40));
    cmp(3'd6, 2'd0, 6'd0, 6'd40, 6'd41, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R7 and.orcm cond false", bulk_rd, 64'd1 | bm(41));
    set_all(bm(40));
    cmp(3'd6, 2'd0, 6'd0, 6'd40, 6'd41, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R7 and.orcm cond true", bulk_rd, 64'd1 | bm(40));
    set_all(bm(41));
    cmp(3'd7, 2'd0, 6'd0, 6'd40, 6'd41, 64'd1, 1'b0, 64'd1, 1'b0);
    check("R7 or.andcm cond true", bulk_rd, 64'd1 | bm(40));
    set_all(bm(41));
    cmp(3'd7, 2'd0, 6'd0, 6'd40, 6'd41, 64'd1, 1'b0, 64'd2, 1'b0);
    check("R7 or.andcm cond false", bulk_rd, 64'd1 | bm(41));
  endtask

  task automatic t_collide;
    set_all(64'd0);
    @(negedge clk);
    bulk_we = 1'b1; bulk_wd = bm(50);
    cmp_valid = 1'b1; cmp_type = 3'd0; cmp_cond = 2'd0; cmp_qp = 6'd0;
    cmp_t1 = 6'd51; cmp_t2 = 6'd52; opa = 64'd1; opb = 64'd1;
    opa_nat = 1'b0; opb_nat = 1'b0;
    #1;
    check("R11 ready low in bulk write", {63'd0, cmp_ready}, 64'd0);
    @(negedge clk);
    bulk_we = 1'b0; cmp_valid = 1'b0;
    check("R11 compare dropped", bulk_rd, 64'd1 | bm(50));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bulk();
    t_normal();
    t_conds();
    t_qp();
    t_nat();
    t_parallel();
    t_mixed();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule